// File: doc/BRIEF.md
# Banked Row-Column Static Memory

This block is a synthesizable behavioural model of a word-addressed static memory built as a grid. Within one memory, the upper part of the word address picks a row through a one-hot row decoder. The lower part picks a column. Every data bit has its own two-dimensional storage plane. Each plane reads the whole selected row at once, and a column multiplexer then reduces that row to the single bit it contributes.

Several of these memories share one data-out bus. The top bits of the incoming address choose the bank, and a bank decoder raises the chip select of exactly one bank while the global select is high. Writes are synchronous: the selected bank stores the input word on the rising clock edge. Reads are combinational from address to bus. The bus is driven only while a bank is selected, its output enable is high and no write is requested. Otherwise it floats, and a separate drive flag reports whether any bank is driving. Geometry is parameterized, so the default build is small enough to sweep every location.

Top module: `sram_bank_bus`

## Requirements
- R1: On a rising clock edge with `mem_sel` and `wr_en` both high, `wr_data` is stored at the word named by `mem_addr`. A later read of that address returns it.
- R2: With `mem_sel` and `rd_en` high and `wr_en` low, `rd_data` shows the stored word in the same cycle that the address is applied, with no clock edge in between, and `bus_driven` is 1.
- R3: Address bits [ROW_BITS+COL_BITS-1:COL_BITS] select the row and bits [COL_BITS-1:0] select the column. Every combination of row and column is a distinct word.
- R4: Each data bit is stored and returned independently. A word whose bits differ from one another reads back exactly as written.
- R5: The top BANK_BITS of `mem_addr` select the bank. A write to one bank leaves the word at the same in-bank offset in every other bank unchanged.
- R6: When `wr_en` and `rd_en` are both high, the write takes priority. The word is stored, and `bus_driven` is 0 in that cycle.
- R7: With `mem_sel` low, no write occurs and `bus_driven` is 0. With `rd_en` low, `bus_driven` is 0. Whenever `bus_driven` is 0, `rd_data` is high impedance.
- R8: At most one bit of `bank_oe` is ever 1, and `bus_driven` equals the OR of `bank_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| mem_addr | input | BANK_BITS+ROW_BITS+COL_BITS (9) | Word address: bank, row, column from MSB to LSB |
| wr_data | input | DATA_W (8) | Word to store |
| mem_sel | input | 1 | Global select; gates every bank's chip select |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| rd_en | input | 1 | Output enable toward the shared bus |
| rd_data | output | DATA_W (8) | Shared bus; high impedance when no bank drives |
| bus_driven | output | 1 | 1 while some bank drives `rd_data` |
| bank_oe | output | NBANKS (4) | Per-bank bus drive enables |

## Verification
Two functions can meet in one cycle: a write request with output enable also high, where the write must win and the bus must stay released. The bench provokes this by asserting both enables on a fresh address. It then judges the flags in the same cycle, and the stored word on a later read. The second meeting point is a read of an address in the cycle right after it was written. Here the reference model, which is updated on each edge, must agree with the combinational read path.

// File: rtl/sram_grid_pkg.sv
package sram_grid_pkg;

    typedef struct packed {
        logic cs;
        logic we;
        logic oe;
    } mem_ctl_t;

endpackage

// File: rtl/sram_row_decoder.sv
module sram_row_decoder #(
    parameter int ROW_BITS = 4
) (
    input  logic [ROW_BITS-1:0]      row_idx,
    output logic [(1<<ROW_BITS)-1:0] word_line
);
    localparam int ROWS = 1 << ROW_BITS;

    always_comb begin
        word_line = '0;
        word_line[row_idx] = 1'b1;
    end

    // R3: exactly one word line is active for any row index
    always_comb begin
        a_r3_one_word_line: assert ($onehot(word_line));
    end

    logic [ROWS-1:0] unused_chk;
    assign unused_chk = word_line;
endmodule

// File: rtl/sram_bit_plane.sv
module sram_bit_plane #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3
) (
    input  logic                     clk,
    input  logic [(1<<ROW_BITS)-1:0] word_line,
    input  logic [COL_BITS-1:0]      col_idx,
    input  logic                     wr,
    input  logic                     wr_bit,
    output logic                     rd_bit
);
    localparam int ROWS = 1 << ROW_BITS;
    localparam int COLS = 1 << COL_BITS;

    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] row_bus;

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wr && word_line[r]) begin
                cells[r][col_idx] <= wr_bit;
            end
        end
    end

    // wide read of the active row, then column multiplexer
    always_comb begin
        row_bus = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (word_line[r]) begin
                row_bus = row_bus | cells[r];
            end
        end
    end

    assign rd_bit = row_bus[col_idx];

    // R4: last written cell reads back the same bit through the column mux
    logic                lw_v;
    logic [ROWS-1:0]     lw_wl;
    logic [COL_BITS-1:0] lw_col;
    logic                lw_bit;

    always_ff @(posedge clk) begin
        if (lw_v && !wr && word_line == lw_wl && col_idx == lw_col) begin
            a_r4_plane_readback: assert (rd_bit == lw_bit);
        end
        if (wr) begin
            lw_v   <= 1'b1;
            lw_wl  <= word_line;
            lw_col <= col_idx;
            lw_bit <= wr_bit;
        end
    end
endmodule

// File: rtl/sram_core.sv
module sram_core
    import sram_grid_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3,
    parameter int DATA_W   = 8
) (
    input  logic                         clk,
    input  logic [ROW_BITS+COL_BITS-1:0] addr,
    input  logic [DATA_W-1:0]            din,
    input  mem_ctl_t                     ctl,
    output logic [DATA_W-1:0]            dout,
    output logic                         drive
);
    localparam int ROWS = 1 << ROW_BITS;

    logic [ROWS-1:0]     word_line;
    logic [COL_BITS-1:0] col_idx;
    logic [DATA_W-1:0]   word;
    logic                wr;

    assign col_idx = addr[COL_BITS-1:0];
    assign wr      = ctl.cs & ctl.we;
    assign drive   = ctl.cs & ctl.oe & ~ctl.we;
    assign dout    = drive ? word : '0;

    sram_row_decoder #(.ROW_BITS(ROW_BITS)) u_rowdec (
        .row_idx   (addr[ROW_BITS+COL_BITS-1:COL_BITS]),
        .word_line (word_line)
    );

    for (genvar b = 0; b < DATA_W; b++) begin : g_plane
        sram_bit_plane #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_plane (
            .clk       (clk),
            .word_line (word_line),
            .col_idx   (col_idx),
            .wr        (wr),
            .wr_bit    (din[b]),
            .rd_bit    (word[b])
        );
    end
endmodule

// File: rtl/sram_bank_bus.sv
module sram_bank_bus
    import sram_grid_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 4,
    parameter int COL_BITS  = 3,
    parameter int DATA_W    = 8
) (
    input  logic                                   clk,
    input  logic [BANK_BITS+ROW_BITS+COL_BITS-1:0] mem_addr,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic                                   mem_sel,
    input  logic                                   wr_en,
    input  logic                                   rd_en,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   bus_driven,
    output logic [(1<<BANK_BITS)-1:0]              bank_oe
);
    localparam int NBANKS = 1 << BANK_BITS;
    localparam int IN_W   = ROW_BITS + COL_BITS;
    localparam int ADDR_W = BANK_BITS + IN_W;

    logic [BANK_BITS-1:0] bank_idx;
    logic [IN_W-1:0]      in_addr;
    logic [NBANKS-1:0]    bank_cs;
    logic [DATA_W-1:0]    bank_dout [NBANKS];
    logic [DATA_W-1:0]    merged;

    assign bank_idx = mem_addr[ADDR_W-1:IN_W];
    assign in_addr  = mem_addr[IN_W-1:0];

    always_comb begin
        bank_cs = '0;
        bank_cs[bank_idx] = mem_sel;
    end

    for (genvar k = 0; k < NBANKS; k++) begin : g_bank
        mem_ctl_t ctl;
        assign ctl = '{cs: bank_cs[k], we: wr_en, oe: rd_en};
        sram_core #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_core (
            .clk   (clk),
            .addr  (in_addr),
            .din   (wr_data),
            .ctl   (ctl),
            .dout  (bank_dout[k]),
            .drive (bank_oe[k])
        );
    end

    always_comb begin
        merged = '0;
        for (int k = 0; k < NBANKS; k++) begin
            merged = merged | bank_dout[k];
        end
    end

    assign bus_driven = |bank_oe;
    assign rd_data    = bus_driven ? merged : {DATA_W{1'bz}};

    always_comb begin
        // R8: no two banks drive the shared bus together
        a_r8_single_driver: assert ($onehot0(bank_oe));
        // R6: a write request keeps every bank off the bus
        if (wr_en) a_r6_write_wins: assert (!bus_driven);
        // R7: a deselected memory never drives
        if (!mem_sel) a_r7_idle_released: assert (bank_oe == '0);
    end
endmodule

// File: tb/test_sram_bank_bus.sv
module test_sram_bank_bus;
    localparam int BANK_BITS = 2;
    localparam int ROW_BITS  = 4;
    localparam int COL_BITS  = 3;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = BANK_BITS + ROW_BITS + COL_BITS;
    localparam int NWORDS    = 1 << ADDR_W;
    localparam int INBANK    = 1 << (ROW_BITS + COL_BITS);

    logic              clk = 1'b0;
    logic [ADDR_W-1:0] t_addr = '0;
    logic [DATA_W-1:0] t_din = '0;
    logic              t_sel = 1'b0;
    logic              t_we = 1'b0;
    logic              t_oe = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              bus_driven;
    logic [3:0]        bank_oe;

    int errors = 0;
    int checks = 0;
    logic [DATA_W-1:0] ref_mem [NWORDS];
    bit                ref_ok  [NWORDS];

    always #5 clk = ~clk;

    sram_bank_bus #(.BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS),
                    .COL_BITS(COL_BITS), .DATA_W(DATA_W)) i_sram_bank_bus (
        .clk        (clk),
        .mem_addr   (t_addr),
        .wr_data    (t_din),
        .mem_sel    (t_sel),
        .wr_en      (t_we),
        .rd_en      (t_oe),
        .rd_data    (rd_data),
        .bus_driven (bus_driven),
        .bank_oe    (bank_oe)
    );

    // reference model: a flat array updated on each edge
    always @(posedge clk) begin
        if (t_sel && t_we) begin
            ref_mem[t_addr] = t_din;
            ref_ok[t_addr]  = 1'b1;
        end
    end

    function automatic logic [DATA_W-1:0] pat(input int a, input int salt);
        return DATA_W'((a * 29 + salt) ^ (a >> 3) ^ (salt << 2));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive after the falling edge and judge before the next rising edge
    task automatic apply(input int a, input int d, input bit s, input bit w,
                         input bit o, input string tag);
        bit exp_drv;
        @(negedge clk);
        t_addr = ADDR_W'(a); t_din = DATA_W'(d); t_sel = s; t_we = w; t_oe = o;
        #2;
        exp_drv = s && o && !w;
        check(bus_driven == exp_drv, {tag, " drive"}, bus_driven, exp_drv);
        check($countones(bank_oe) <= 1 && (|bank_oe) == bus_driven,
              "R8 bank_oe", bank_oe, 0);
        if (exp_drv && ref_ok[a]) begin
            check(rd_data === ref_mem[a], {tag, " data"}, rd_data, ref_mem[a]);
        end
    endtask

    initial begin
        #1ms;
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < NWORDS; a++) ref_ok[a] = 1'b0;
        // reset state: idle memory does not drive
        apply(0, 0, 0, 0, 0, "R7 idle");
        // R1 R3 R4: fill every location, each word with varied bits
        for (int a = 0; a < NWORDS; a++) apply(a, pat(a, 11), 1, 1, 0, "R1 fill");
        // R2 R3 R4: combinational read of every location
        for (int a = 0; a < NWORDS; a++) apply(a, 0, 1, 0, 1, "R2 sweep");
        // R7: deselected write must not store
        apply(5, 8'hA5, 0, 1, 0, "R7 desel write");
        apply(5, 0, 1, 0, 1, "R7 desel readback");
        check(rd_data === pat(5, 11), "R7 unchanged", rd_data, pat(5, 11));
        // R7: output enable low releases the bus
        apply(5, 0, 1, 0, 0, "R7 oe low");
        // R6: write and output enable together, write wins
        apply(77, 8'h3C, 1, 1, 1, "R6 collide");
        apply(77, 0, 1, 0, 1, "R6 readback");
        check(rd_data === 8'h3C, "R6 stored", rd_data, 8'h3C);
        // R5: write one bank, other banks' same offset unaffected
        apply(INBANK + 9, 8'hFF, 1, 1, 0, "R5 write bank1");
        for (int k = 0; k < 4; k++) apply(k * INBANK + 9, 0, 1, 0, 1, "R5 neighbours");
        // R1 R2: read in the cycle right after a write; alternating bit patterns
        for (int a = 0; a < 32; a++) begin
            apply(a * 13 % NWORDS, (a & 1) ? 8'h55 : 8'hAA, 1, 1, 0, "R1 rewrite");
            apply(a * 13 % NWORDS, 0, 1, 0, 1, "R2 back to back");
        end
        // R3: column and row boundary corners of the last bank
        apply(NWORDS - 1, 0, 1, 0, 1, "R3 top corner");
        apply(NWORDS - INBANK, 0, 1, 0, 1, "R3 bottom corner");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule